// File: doc/BRIEF.md
# Double-Buffered Colour Palette

This block converts 8-bit pixel indices into 24-bit RGB colours through a 256-entry lookup table that has two banks. At any moment one bank is displayed and the other is hidden. Software fills the hidden bank over a simple register-write port, so a partly written palette never reaches the screen.

Software asks for a swap by writing a new value to a select bit in the control register. The display side takes the selected bank only when a frame-start pulse arrives, which keeps a frame from being drawn with two palettes. A status bit in the same register reports which bank is live. When the status bit equals the select bit, the last swap has completed and the hidden bank is free to be refilled. Pixel lookups come out one clock after the index is presented, with a matching valid flag.

Top module: `palette_dbuf`

## Requirements
- R1: Table writes address an entry by byte offset: `wr_addr[9:2]` is the entry index (0 to 255) and `wr_addr[1:0]` has no effect.
- R2: An entry holds 24 bits laid out as red in 23:16, green in 15:8 and blue in 7:0. It is taken from `wr_data[23:0]`, and `wr_data[31:24]` is ignored. A lookup returns the stored 24 bits unchanged on `out_rgb`.
- R3: `ctl_rdata` reads as follows: bit 0 is the swap-select bit, bit 1 is the displayed bank, and bits 31:2 are zero. Bit 0 changes only on a cycle with `ctl_wr_en` high, and then takes `ctl_wdata[0]`.
- R4: A table write goes to the bank that is not displayed in that cycle. It never changes a value returned by a lookup of the displayed bank.
- R5: The displayed bank, and so status bit 1, changes only on a cycle with `frame_start` high. It then takes the swap-select value held before that clock edge, even when a control write occurs in the same cycle.
- R6: While the status bit equals the select bit (swap completed), `frame_start` leaves the displayed bank unchanged. A select change with no `frame_start` leaves the display on the old bank.
- R7: When `pix_valid` is high, `out_valid` is high one clock later and `out_rgb` is the entry at `pix_index` of the bank displayed in the cycle the index was sampled. When `pix_valid` is low, `out_valid` is low one clock later.
- R8: After reset, bank 0 is displayed, both control bits read 0, and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table entry write strobe |
| wr_addr | input | 10 | Byte offset of the entry (index times 4) |
| wr_data | input | 32 | Entry write data, RGB in bits 23:0 |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data, bit 0 is swap-select |
| ctl_rdata | output | 32 | Control/status readback |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| pix_valid | input | 1 | Pixel index valid |
| pix_index | input | 8 | Pixel colour index |
| out_valid | output | 1 | Looked-up colour valid |
| out_rgb | output | 24 | Looked-up colour |

## Verification
The checker covers the control timing on every cycle. It checks that the status bit moves only on frame-start and then takes the earlier select value, that it holds when the swap has already completed, that the select bit moves only on control writes, and that the output valid flag follows the input valid flag by one clock. Only the bench scenarios show the colour data itself. These scenarios cover filling each bank while the other is shown, writes to the hidden bank that leave the displayed colours untouched, ignored offset and upper data bits, a swap that waits pending across several cycles, and a control write that coincides with a frame boundary.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    BANK_0 = 1'b0,
    BANK_1 = 1'b1
  } bank_e;

  // Position of the swap-select and status fields in the control word.
  localparam int unsigned CTL_SEL_BIT  = 0;
  localparam int unsigned CTL_STAT_BIT = 1;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_0) ? BANK_1 : BANK_0;
  endfunction
endpackage

// File: rtl/palette_rst_sync.sv
module palette_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/palette_bank.sv
module palette_bank #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DAT_W = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DAT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DAT_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem_q [DEPTH];

  // Storage array: no reset, written only through the enable.
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/palette_swap_ctrl.sv
module palette_swap_ctrl
  import palette_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_wr_en,
  input  logic  ctl_sel_in,
  input  logic  frame_start,
  output bank_e sel_bank,
  output bank_e live_bank
);
  bank_e sel_q, sel_d;
  bank_e live_q, live_d;
  logic  sel_en, live_en;

  always_comb begin
    sel_en  = ctl_wr_en;
    sel_d   = bank_e'(ctl_sel_in);
    live_en = frame_start && (live_q != sel_q);
    live_d  = sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= BANK_0;
      live_q <= BANK_0;
    end else begin
      if (sel_en)  sel_q  <= sel_d;
      if (live_en) live_q <= live_d;
    end
  end

  assign sel_bank  = sel_q;
  assign live_bank = live_q;
endmodule

// File: rtl/palette_dbuf.sv
module palette_dbuf
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  parameter int unsigned BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W+1:0]     wr_addr,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic                 ctl_wr_en,
  input  logic [BUS_W-1:0]     ctl_wdata,
  output logic [BUS_W-1:0]     ctl_rdata,
  input  logic                 frame_start,
  input  logic                 pix_valid,
  input  logic [IDX_W-1:0]     pix_index,
  output logic                 out_valid,
  output logic [3*CH_W-1:0]    out_rgb
);
  localparam int unsigned RGB_W = 3 * CH_W;

  logic             rst_n_i;
  bank_e            sel_bank, live_bank, hidden_bank;
  logic [RGB_W-1:0] bank_rd [NUM_BANKS];
  logic [RGB_W-1:0] rgb_d, rgb_q;
  logic             vld_q;
  logic             rgb_en;

  palette_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  palette_swap_ctrl u_swap (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_sel_in  (ctl_wdata[CTL_SEL_BIT]),
    .frame_start (frame_start),
    .sel_bank    (sel_bank),
    .live_bank   (live_bank)
  );

  assign hidden_bank = other_bank(live_bank);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    palette_bank #(.IDX_W(IDX_W), .DAT_W(RGB_W)) u_bank (
      .clk   (clk),
      .we    (wr_en && (hidden_bank == bank_e'(b))),
      .waddr (wr_addr[IDX_W+1:2]),
      .wdata (wr_data[RGB_W-1:0]),
      .raddr (pix_index),
      .rdata (bank_rd[b])
    );
  end

  always_comb begin
    rgb_en = pix_valid;
    rgb_d  = bank_rd[live_bank];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      vld_q <= 1'b0;
      rgb_q <= '0;
    end else begin
      vld_q <= pix_valid;
      if (rgb_en) rgb_q <= rgb_d;
    end
  end

  always_comb begin
    ctl_rdata               = '0;
    ctl_rdata[CTL_SEL_BIT]  = sel_bank;
    ctl_rdata[CTL_STAT_BIT] = live_bank;
  end

  assign out_valid = vld_q;
  assign out_rgb   = rgb_q;
endmodule

// File: rtl/palette_dbuf_chk.sv
module palette_dbuf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr_en,
  input logic [31:0] ctl_rdata,
  input logic        frame_start,
  input logic        pix_valid,
  input logic        out_valid
);
  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(ctl_rdata[1]));

  assert_status_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ctl_rdata[1] == $past(ctl_rdata[0])));

  assert_done_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[0] == ctl_rdata[1]) |=> $stable(ctl_rdata[1]));

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_rdata[0]));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[31:2] == '0);

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
endmodule

bind palette_dbuf palette_dbuf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_rdata   (ctl_rdata),
  .frame_start (frame_start),
  .pix_valid   (pix_valid),
  .out_valid   (out_valid)
);

// File: tb/test_palette_dbuf.sv
module test_palette_dbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_index = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2 clk = ~clk; // 250 MHz

  palette_dbuf i_palette_dbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .frame_start(frame_start), .pix_valid(pix_valid), .pix_index(pix_index),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // Behavioural reference model
  logic [23:0] m_tab [2][256];
  int          m_live = 0;
  int          m_sel = 0;
  logic        m_vld = 1'b0;
  logic [23:0] m_rgb = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 0; m_sel = 0; m_vld = 1'b0;
    end else begin
      int old_live;
      int old_sel;
      old_live = m_live;
      old_sel  = m_sel;
      m_vld = pix_valid;
      if (pix_valid) m_rgb = m_tab[old_live][pix_index];
      if (wr_en) m_tab[1 - old_live][wr_addr >> 2] = wr_data[23:0];
      if (frame_start) m_live = old_sel;
      if (ctl_wr_en) m_sel = int'(ctl_wdata[0]);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R3/R5/R8 ctl_rdata", ctl_rdata, {30'd0, m_live[0], m_sel[0]});
      check("R7/R8 out_valid", {31'd0, out_valid}, {31'd0, m_vld});
      if (m_vld) check("R2/R4/R7 out_rgb", {8'd0, out_rgb}, {8'd0, m_rgb});
    end
    if (cycles > 200000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // One cycle of stimulus; called at a negedge, returns at the next negedge
  task automatic cyc(input logic we, input logic [9:0] a, input logic [31:0] d,
                     input logic cw, input logic [31:0] cd, input logic fs,
                     input logic pv, input logic [7:0] pi);
    wr_en = we; wr_addr = a; wr_data = d;
    ctl_wr_en = cw; ctl_wdata = cd; frame_start = fs;
    pix_valid = pv; pix_index = pi;
    @(negedge clk);
    wr_en = 0; ctl_wr_en = 0; frame_start = 0; pix_valid = 0;
  endtask

  task automatic fill(input int gen);
    for (int i = 0; i < 256; i++) begin
      // R1: low offset bits vary and must not matter; R2: top byte is junk
      cyc(1, 10'((i << 2) | (i & 3)), {8'hC3 ^ 8'(i), 8'(i ^ (gen * 37)), 8'(~i), 8'(i + gen * 11)},
          0, 0, 0, 0, 0);
    end
  endtask

  task automatic sweep(input int step);
    for (int i = 0; i < 256; i += step) cyc(0, 0, 0, 0, 0, 0, 1, 8'(i));
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R8: reset state
    check("R8 reset ctl_rdata", ctl_rdata, 32'd0);
    check("R8 reset out_valid", {31'd0, out_valid}, 32'd0);

    fill(1);                         // R4: lands in bank 1 (hidden)
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0); // select bank 1, upper bits ignored
    idle(3);                         // R6: still pending, status stays 0
    check("R6 pending status", ctl_rdata, 32'h1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);     // R5: frame boundary
    check("R5 swap to bank 1", ctl_rdata, 32'h3);
    fill(2);                         // now bank 0 hidden
    sweep(1);                        // R7 back-to-back from bank 1
    cyc(0, 0, 0, 0, 0, 1, 1, 8'd7);  // R6: completed swap, frame_start no effect
    check("R6 no change", ctl_rdata, 32'h3);

    // R4: writes to hidden bank interleaved with reads of the same index
    for (int i = 0; i < 40; i++) begin
      cyc(1, 10'(i * 4), 32'h00AB_CD00 | 32'(i), 0, 0, 0, 1, 8'(i));
      cyc(0, 0, 0, 0, 0, 0, 1, 8'(i));
    end

    // R5: control write coinciding with frame_start uses old select
    cyc(0, 0, 0, 1, 32'h0, 0, 0, 0);
    cyc(0, 0, 0, 1, 32'h1, 1, 1, 8'd3); // old select is 0 -> bank 0
    check("R5 coincident write", ctl_rdata, 32'h1);
    sweep(3);                        // pixels from bank 0
    cyc(0, 0, 0, 0, 0, 1, 1, 8'd255); // swap to bank 1 with a pixel in flight
    sweep(5);
    // gaps in valid
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 0, 0, 0, i[0], 8'(i * 9));
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule